// File: doc/BRIEF.md
# PC-Relative Address Generation Unit

This execute-stage unit recognises the instruction that forms an address relative to the program counter. It handles two instruction sets: a fixed-width 32-bit set, and a compact set that mixes 16-bit and 32-bit instructions. For each strobed instruction word it works out which of five encodings is present and extracts the destination register and the offset field. It widens the offset by the rule of that encoding, then adds the offset to, or subtracts it from, the word-aligned program counter.

One cycle after the strobe, the result goes out on one of two ports. The register-write port serves ordinary destinations. The branch port serves a fixed-width instruction whose destination is the program counter. A compact 32-bit encoding that names the program counter raises an unpredictable flag and writes nothing. A word that matches no encoding raises an invalid flag and writes nothing. The outer pipeline evaluates the condition code and supplies the result as a single pass input. The register file and instruction fetch are outside this block.

Top module: `pcrel_addr_unit`

## Requirements
- R1: While reset is asserted, and after it, all outputs are zero until the first strobe: out_valid_o, rf_we_o, br_valid_o, unpred_o and invalid_o are low, and rf_wdata_o, rf_waddr_o and br_target_o are zero.
- R2: out_valid_o is high in exactly the cycle after a cycle with valid_i high. When valid_i is low, rf_we_o, br_valid_o, unpred_o and invalid_o are low in the following cycle.
- R3: Fixed-width add form (compact_i=0). Bits 27:16 equal 0b001010001111, Rd is bits 15:12 and the 12-bit field is bits 11:0. The offset is the low 8 bits, zero-extended and rotated right by twice bits 11:8. The result is align4(addr_i+8) plus the offset, modulo 2^32.
- R4: Fixed-width subtract form. Bits 27:16 equal 0b001001001111, with the same field layout and offset rule as R3. The result is align4(addr_i+8) minus the offset, and it wraps modulo 2^32.
- R5: A fixed-width word whose bits 31:28 equal 0b1111 is not either form of R3 or R4. Any other value in bits 31:28 is accepted.
- R6: Compact 16-bit form (compact_i=1). The instruction sits in instr_i[31:16], and bits 31:27 equal 0b10100. Rd is bits 26:24 and imm8 is bits 23:16. The result is align4(addr_i+4) + imm8*4.
- R7: Compact 32-bit forms. The first halfword is instr_i[31:16] and the second is instr_i[15:0]. The first halfword holds 0b11110 in bits 15:11, i in bit 10, and 0b1111 in bits 3:0. Its bits 9:4 equal 0b100000 for add and 0b101010 for subtract. In the second halfword, bit 15 is 0, imm3 is bits 14:12, Rd is bits 11:8 and imm8 is bits 7:0. The offset is i:imm3:imm8, zero-extended. The result is align4(addr_i+4) plus or minus that offset.
- R8: The two low bits of the incremented address are cleared before the offset is applied.
- R9: A fixed-width form with Rd=15 and the condition passing sets br_valid_o instead of rf_we_o. br_target_o is the result with bit 0 cleared, and br_compact_o is bit 0 of the result.
- R10: A compact 32-bit form with Rd=15 and the condition passing sets unpred_o and writes nothing.
- R11: When cond_pass_i is low, a recognised instruction sets neither rf_we_o, br_valid_o nor unpred_o.
- R12: A word that matches no encoding for the selected instruction set sets invalid_o and no write. This includes a compact 32-bit word whose second-halfword bit 15 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Instruction strobe |
| compact_i | input | 1 | 1 selects the compact instruction set |
| instr_i | input | 32 | Instruction word (compact: first halfword in 31:16) |
| addr_i | input | 32 | Address of the instruction |
| cond_pass_i | input | 1 | Condition evaluated as passing |
| out_valid_o | output | 1 | Result cycle for the previous strobe |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 4 | Register write index |
| rf_wdata_o | output | 32 | Computed address |
| br_valid_o | output | 1 | Branch to computed address |
| br_target_o | output | 32 | Branch target, bit 0 cleared |
| br_compact_o | output | 1 | Branch target is in the compact set |
| unpred_o | output | 1 | Unpredictable destination |
| invalid_o | output | 1 | No encoding matched |

## Verification
On every cycle, the assertions check the one-cycle result timing and that the register and branch ports are never both active. They also check that the invalid, unpredictable and failed-condition cases suppress every write, that a compact strobe never produces a branch, that branch targets have bit 0 clear, and that a reserved condition field always yields invalid. The exact arithmetic can only be shown by the bench's scenarios: the rotated immediate, the subtraction that wraps, clearing of the alignment bits for odd-halfword addresses, and the bit-0 set selection. The bench's scenarios are also the only place that shows outputs clearing under a reset in mid-run and results following each other on back-to-back strobes.

// File: rtl/pcrel_pkg.sv
package pcrel_pkg;

  localparam int INSN_W = 32;
  localparam int REG_W  = 4;

  typedef enum logic [2:0] {
    FORM_NONE    = 3'd0,
    FORM_W_ADD   = 3'd1,
    FORM_W_SUB   = 3'd2,
    FORM_C16     = 3'd3,
    FORM_C32_ADD = 3'd4,
    FORM_C32_SUB = 3'd5
  } form_e;

  // fixed-width opcode field, bits 27:16
  localparam logic [11:0] WIDE_ADD_OP = 12'b0010_1000_1111;
  localparam logic [11:0] WIDE_SUB_OP = 12'b0010_0100_1111;
  localparam logic [3:0]  COND_RSVD   = 4'b1111;

  // compact set patterns
  localparam logic [4:0]  C16_OP      = 5'b10100;
  localparam logic [4:0]  C32_HDR     = 5'b11110;
  localparam logic [5:0]  C32_ADD_OP  = 6'b100000;
  localparam logic [5:0]  C32_SUB_OP  = 6'b101010;
  localparam logic [3:0]  C32_BASE    = 4'b1111;

  localparam logic [REG_W-1:0] PC_IDX = 4'd15;

endpackage

// File: rtl/pcrel_decode.sv
module pcrel_decode
  import pcrel_pkg::*;
(
  input  logic              compact_i,
  input  logic [INSN_W-1:0] instr_i,
  output form_e             form_o,
  output logic [REG_W-1:0]  rd_o,
  output logic [11:0]       field_o
);

  logic [15:0] hw_hi;
  logic [15:0] hw_lo;
  logic        cond_ok;
  logic        hit_w_add;
  logic        hit_w_sub;
  logic        hit_c16;
  logic        c32_frame;
  logic        hit_c32_add;
  logic        hit_c32_sub;

  assign hw_hi = instr_i[31:16];
  assign hw_lo = instr_i[15:0];

  always_comb begin
    cond_ok     = (instr_i[31:28] != COND_RSVD);
    hit_w_add   = !compact_i && cond_ok && (instr_i[27:16] == WIDE_ADD_OP);
    hit_w_sub   = !compact_i && cond_ok && (instr_i[27:16] == WIDE_SUB_OP);
    hit_c16     = compact_i && (hw_hi[15:11] == C16_OP);
    c32_frame   = compact_i && (hw_hi[15:11] == C32_HDR) &&
                  (hw_hi[3:0] == C32_BASE) && !hw_lo[15];
    hit_c32_add = c32_frame && (hw_hi[9:4] == C32_ADD_OP);
    hit_c32_sub = c32_frame && (hw_hi[9:4] == C32_SUB_OP);
  end

  always_comb begin
    form_o  = FORM_NONE;
    rd_o    = '0;
    field_o = '0;
    if (hit_w_add || hit_w_sub) begin
      form_o  = hit_w_add ? FORM_W_ADD : FORM_W_SUB;
      rd_o    = instr_i[15:12];
      field_o = instr_i[11:0];
    end else if (hit_c16) begin
      form_o  = FORM_C16;
      rd_o    = {1'b0, hw_hi[10:8]};
      field_o = {4'b0000, hw_hi[7:0]};
    end else if (hit_c32_add || hit_c32_sub) begin
      form_o  = hit_c32_add ? FORM_C32_ADD : FORM_C32_SUB;
      rd_o    = hw_lo[11:8];
      field_o = {hw_hi[10], hw_lo[14:12], hw_lo[7:0]};
    end
  end

endmodule

// File: rtl/pcrel_immexp.sv
module pcrel_immexp
  import pcrel_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  form_e            form_i,
  input  logic [11:0]      field_i,
  output logic [XLEN-1:0]  imm_o,
  output logic             add_o
);

  localparam int ROT_W = $clog2(XLEN);

  logic [XLEN-1:0]  base8;
  logic [ROT_W-1:0] rot_amt;
  logic [XLEN-1:0]  rotated;

  always_comb begin
    base8   = {{(XLEN-8){1'b0}}, field_i[7:0]};
    rot_amt = ROT_W'({field_i[11:8], 1'b0});
    rotated = (base8 >> rot_amt) | (base8 << (XLEN - int'(rot_amt)));
  end

  always_comb begin
    imm_o = '0;
    add_o = 1'b1;
    unique case (form_i)
      FORM_W_ADD:   begin imm_o = rotated; add_o = 1'b1; end
      FORM_W_SUB:   begin imm_o = rotated; add_o = 1'b0; end
      FORM_C16:     begin imm_o = {{(XLEN-10){1'b0}}, field_i[7:0], 2'b00}; add_o = 1'b1; end
      FORM_C32_ADD: begin imm_o = {{(XLEN-12){1'b0}}, field_i}; add_o = 1'b1; end
      FORM_C32_SUB: begin imm_o = {{(XLEN-12){1'b0}}, field_i}; add_o = 1'b0; end
      default:      begin imm_o = '0; add_o = 1'b1; end
    endcase
  end

endmodule

// File: rtl/pcrel_agu.sv
module pcrel_agu #(
  parameter int XLEN        = 32,
  parameter int WIDE_PC_OFS = 8,
  parameter int CMPT_PC_OFS = 4,
  parameter int ALIGN_BYTES = 4
) (
  input  logic            compact_i,
  input  logic [XLEN-1:0] addr_i,
  input  logic [XLEN-1:0] imm_i,
  input  logic            add_i,
  output logic [XLEN-1:0] result_o
);

  localparam int ALIGN_W = $clog2(ALIGN_BYTES);

  logic [XLEN-1:0] pc_view;
  logic [XLEN-1:0] pc_aligned;

  always_comb begin
    pc_view = addr_i + (compact_i ? XLEN'(CMPT_PC_OFS) : XLEN'(WIDE_PC_OFS));
  end

  generate
    if (ALIGN_W > 0) begin : g_align
      assign pc_aligned = {pc_view[XLEN-1:ALIGN_W], {ALIGN_W{1'b0}}};
    end else begin : g_noalign
      assign pc_aligned = pc_view;
    end
  endgenerate

  always_comb begin
    result_o = add_i ? (pc_aligned + imm_i) : (pc_aligned - imm_i);
  end

endmodule

// File: rtl/pcrel_addr_unit.sv
module pcrel_addr_unit
  import pcrel_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int WIDE_PC_OFS = 8,
  parameter int CMPT_PC_OFS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid_i,
  input  logic             compact_i,
  input  logic [31:0]      instr_i,
  input  logic [XLEN-1:0]  addr_i,
  input  logic             cond_pass_i,
  output logic             out_valid_o,
  output logic             rf_we_o,
  output logic [3:0]       rf_waddr_o,
  output logic [XLEN-1:0]  rf_wdata_o,
  output logic             br_valid_o,
  output logic [XLEN-1:0]  br_target_o,
  output logic             br_compact_o,
  output logic             unpred_o,
  output logic             invalid_o
);

  typedef struct packed {
    logic vld;
    logic we;
    logic br;
    logic unp;
    logic inv;
  } flags_t;

  form_e            form;
  logic [REG_W-1:0] rd;
  logic [11:0]      field;
  logic [XLEN-1:0]  imm;
  logic             add;
  logic [XLEN-1:0]  result;

  pcrel_decode u_decode (
    .compact_i (compact_i),
    .instr_i   (instr_i),
    .form_o    (form),
    .rd_o      (rd),
    .field_o   (field)
  );

  pcrel_immexp #(.XLEN(XLEN)) u_immexp (
    .form_i  (form),
    .field_i (field),
    .imm_o   (imm),
    .add_o   (add)
  );

  pcrel_agu #(
    .XLEN        (XLEN),
    .WIDE_PC_OFS (WIDE_PC_OFS),
    .CMPT_PC_OFS (CMPT_PC_OFS)
  ) u_agu (
    .compact_i (compact_i),
    .addr_i    (addr_i),
    .imm_i     (imm),
    .add_i     (add),
    .result_o  (result)
  );

  // next-state
  logic             is_wide;
  logic             is_c32;
  logic             pc_dest;
  flags_t           flags_d, flags_q;
  logic             data_en;
  logic [REG_W-1:0] waddr_q;
  logic [XLEN-1:0]  result_q;

  always_comb begin
    is_wide = (form == FORM_W_ADD) || (form == FORM_W_SUB);
    is_c32  = (form == FORM_C32_ADD) || (form == FORM_C32_SUB);
    pc_dest = (rd == PC_IDX);
    data_en = valid_i;
    flags_d = '0;
    if (valid_i) begin
      flags_d.vld = 1'b1;
      flags_d.inv = (form == FORM_NONE);
      flags_d.we  = cond_pass_i && (form != FORM_NONE) && !pc_dest;
      flags_d.br  = cond_pass_i && is_wide && pc_dest;
      flags_d.unp = cond_pass_i && is_c32 && pc_dest;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waddr_q  <= '0;
      result_q <= '0;
    end else if (data_en) begin
      waddr_q  <= rd;
      result_q <= result;
    end
  end

  assign out_valid_o  = flags_q.vld;
  assign rf_we_o      = flags_q.we;
  assign br_valid_o   = flags_q.br;
  assign unpred_o     = flags_q.unp;
  assign invalid_o    = flags_q.inv;
  assign rf_waddr_o   = waddr_q;
  assign rf_wdata_o   = result_q;
  assign br_target_o  = {result_q[XLEN-1:1], 1'b0};
  assign br_compact_o = result_q[0];

endmodule

// File: rtl/pcrel_addr_unit_chk.sv
module pcrel_addr_unit_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            valid_i,
  input logic            compact_i,
  input logic [31:0]     instr_i,
  input logic            cond_pass_i,
  input logic            out_valid_o,
  input logic            rf_we_o,
  input logic [3:0]      rf_waddr_o,
  input logic [XLEN-1:0] rf_wdata_o,
  input logic            br_valid_o,
  input logic [XLEN-1:0] br_target_o,
  input logic            unpred_o,
  input logic            invalid_o
);

  // R2
  result_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_i |=> out_valid_o);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_i |=> !(out_valid_o || rf_we_o || br_valid_o || unpred_o || invalid_o));

  // R9
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we_o && br_valid_o));

  // R9
  target_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_valid_o |-> !br_target_o[0]);

  // R9
  compact_no_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && compact_i) |=> !br_valid_o);

  // R10
  unpred_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unpred_o |-> !(rf_we_o || br_valid_o));

  // R11
  cond_fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !cond_pass_i) |=> !(rf_we_o || br_valid_o || unpred_o));

  // R12
  invalid_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_o |-> !(rf_we_o || br_valid_o || unpred_o));

  // R5
  reserved_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !compact_i && instr_i[31:28] == 4'hF) |=> invalid_o);

  // R6
  c16_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && compact_i && cond_pass_i && instr_i[31:27] == 5'b10100) |=>
      (rf_we_o && rf_wdata_o[1:0] == 2'b00 && !rf_waddr_o[3]));

endmodule

bind pcrel_addr_unit pcrel_addr_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .valid_i     (valid_i),
  .compact_i   (compact_i),
  .instr_i     (instr_i),
  .cond_pass_i (cond_pass_i),
  .out_valid_o (out_valid_o),
  .rf_we_o     (rf_we_o),
  .rf_waddr_o  (rf_waddr_o),
  .rf_wdata_o  (rf_wdata_o),
  .br_valid_o  (br_valid_o),
  .br_target_o (br_target_o),
  .unpred_o    (unpred_o),
  .invalid_o   (invalid_o)
);

// File: tb/tb_pcrel_addr_unit.sv
`timescale 1ns/100ps
module tb_pcrel_addr_unit;

  logic        clk;
  logic        rst_n;
  logic        valid_i;
  logic        compact_i;
  logic [31:0] instr_i;
  logic [31:0] addr_i;
  logic        cond_pass_i;
  logic        out_valid_o;
  logic        rf_we_o;
  logic [3:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic        br_valid_o;
  logic [31:0] br_target_o;
  logic        br_compact_o;
  logic        unpred_o;
  logic        invalid_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  pcrel_addr_unit dut (
    .clk (clk), .rst_n (rst_n), .valid_i (valid_i), .compact_i (compact_i),
    .instr_i (instr_i), .addr_i (addr_i), .cond_pass_i (cond_pass_i),
    .out_valid_o (out_valid_o), .rf_we_o (rf_we_o), .rf_waddr_o (rf_waddr_o),
    .rf_wdata_o (rf_wdata_o), .br_valid_o (br_valid_o), .br_target_o (br_target_o),
    .br_compact_o (br_compact_o), .unpred_o (unpred_o), .invalid_o (invalid_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct packed {
    logic        cmp;
    logic [31:0] ins;
    logic [31:0] addr;
    logic        cp;
    logic        we;
    logic [3:0]  wa;
    logic [31:0] wd;
    logic        br;
    logic [31:0] tgt;
    logic        brc;
    logic        unp;
    logic        inv;
  } vec_t;

  localparam int NVEC = 17;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 32'hE28F3010, 32'h00001000, 1'b1, 1'b1, 4'd3,  32'h00001018, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R3
    '{1'b0, 32'hE28F54FF, 32'h00002000, 1'b1, 1'b1, 4'd5,  32'hFF002008, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R3 rotate
    '{1'b0, 32'hE24F1F01, 32'h00000100, 1'b1, 1'b1, 4'd1,  32'h00000104, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R4
    '{1'b0, 32'hE24F20FF, 32'h00000000, 1'b1, 1'b1, 4'd2,  32'hFFFFFF09, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R4 wrap
    '{1'b1, 32'hA6050000, 32'h00003002, 1'b1, 1'b1, 4'd6,  32'h00003018, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R6 R8
    '{1'b1, 32'hF6AF2434, 32'h00008000, 1'b1, 1'b1, 4'd4,  32'h000075D0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R7 sub
    '{1'b1, 32'hF20F7DFF, 32'h00004002, 1'b1, 1'b1, 4'd13, 32'h00004803, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R7 add, R8
    '{1'b0, 32'hE28FF001, 32'h00000500, 1'b1, 1'b0, 4'd0,  32'h0, 1'b1, 32'h00000508, 1'b1, 1'b0, 1'b0}, // R9
    '{1'b0, 32'hE24FF004, 32'h00000600, 1'b1, 1'b0, 4'd0,  32'h0, 1'b1, 32'h00000604, 1'b0, 1'b0, 1'b0}, // R9
    '{1'b1, 32'hF20F0F10, 32'h00000000, 1'b1, 1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0}, // R10
    '{1'b0, 32'hF28F3010, 32'h00000000, 1'b1, 1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1}, // R5
    '{1'b0, 32'hE3A01000, 32'h00000000, 1'b1, 1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1}, // R12
    '{1'b1, 32'hE28F3010, 32'h00000000, 1'b1, 1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1}, // R12 wrong set
    '{1'b0, 32'hE28F3010, 32'h00001000, 1'b0, 1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R11
    '{1'b1, 32'hF20F8010, 32'h00000000, 1'b1, 1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1}, // R12 bit15
    '{1'b0, 32'h128F3010, 32'h00000000, 1'b1, 1'b1, 4'd3,  32'h00000018, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}, // R5 other cond
    '{1'b1, 32'hF20F0F10, 32'h00000000, 1'b0, 1'b0, 4'd0,  32'h0, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0}  // R11 no unpred
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    compact_i   = v.cmp;
    instr_i     = v.ins;
    addr_i      = v.addr;
    cond_pass_i = v.cp;
    valid_i     = 1'b1;
  endtask

  task automatic check_vec(input int idx, input vec_t v);
    string t;
    t = $sformatf("vec%0d", idx);
    check({t, " R2 out_valid"}, 32'(out_valid_o), 32'd1);
    check({t, " R11 rf_we"},    32'(rf_we_o),     32'(v.we));
    check({t, " R9 br_valid"},  32'(br_valid_o),  32'(v.br));
    check({t, " R10 unpred"},   32'(unpred_o),    32'(v.unp));
    check({t, " R12 invalid"},  32'(invalid_o),   32'(v.inv));
    if (v.we) begin
      check({t, " R3 waddr"}, 32'(rf_waddr_o), 32'(v.wa));
      check({t, " R4 wdata"}, rf_wdata_o, v.wd);
    end
    if (v.br) begin
      check({t, " R9 target"},  br_target_o, v.tgt);
      check({t, " R9 compact"}, 32'(br_compact_o), 32'(v.brc));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; valid_i = 1'b0; compact_i = 1'b0;
    instr_i = '0; addr_i = '0; cond_pass_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 out_valid", 32'(out_valid_o), 0);
    check("R1 rf_we",     32'(rf_we_o), 0);
    check("R1 br_valid",  32'(br_valid_o), 0);
    check("R1 flags",     32'({unpred_o, invalid_o}), 0);
    check("R1 wdata",     rf_wdata_o, 0);
    check("R1 target",    br_target_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 32'({out_valid_o, rf_we_o, br_valid_o, unpred_o, invalid_o}), 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      valid_i = 1'b0;
      check_vec(i, VECS[i]);
      @(negedge clk);
      // R2 quiet after idle cycle
      check($sformatf("vec%0d R2 idle", i),
            32'({out_valid_o, rf_we_o, br_valid_o, unpred_o, invalid_o}), 0);
    end

    // R2 back-to-back strobes
    drive(VECS[0]);
    @(negedge clk);
    drive(VECS[4]);
    check("R2 b2b first wdata", rf_wdata_o, VECS[0].wd);
    @(negedge clk);
    valid_i = 1'b0;
    check("R2 b2b second wdata", rf_wdata_o, VECS[4].wd);
    check("R2 b2b second waddr", 32'(rf_waddr_o), 32'(VECS[4].wa));
    @(negedge clk);

    // R8 each low address offset in compact set lands on the same aligned base
    for (int k = 0; k < 4; k++) begin
      vec_t v;
      v = VECS[4];
      v.addr = 32'h00003000 + 32'(k);
      drive(v);
      @(negedge clk);
      valid_i = 1'b0;
      check($sformatf("R8 low=%0d", k), rf_wdata_o, 32'h00003018);
    end

    // R1 reset in mid-run clears outputs
    drive(VECS[7]);
    @(negedge clk);
    valid_i = 1'b0;
    check("R9 before reset", 32'(br_valid_o), 1);
    #1 rst_n = 1'b0;
    #1;
    check("R1 midrun flags", 32'({out_valid_o, rf_we_o, br_valid_o, unpred_o, invalid_o}), 0);
    check("R1 midrun data", rf_wdata_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule